// File: doc/BRIEF.md
# Hash Engine Buffer Handshake Controller

This block owns the single 32-bit control and status word that a host uses to drive a block-based hash core. The host loads an input block into the core's data registers (outside this block), then writes request bits into the control word. A small sequencer turns those requests into one launch pulse toward the core, tagged with "carries data", "apply padding" and "publish digest" flags. It waits for the core to report completion and then commits the digest into the output registers. A full flag guards those output registers: a new digest is held back until the host has released the previous one by writing 1 to that flag.

Request bits are write-1-to-set and clear themselves when the sequencer consumes them. Writing 0 to any bit has no effect. A digest request may travel with a data block or be issued alone, and then the core's running state is snapshotted. A padding request may also be issued alone after an exactly block-sized final block has already been taken. For the DMA-fed path, a separate padding flag is presented to the core as a level and cleared when the last DMA block arrives.

The sequencer has four states. **IDLE** is the state in which ready-for-data reads 1. **LAUNCH** drives the one-cycle start pulse. **RUN** waits for the core's done pulse. **PUBLISH** waits until the full flag is clear and then commits the digest. Its transitions are:
- IDLE→LAUNCH: any of data-available, pad or digest is pending.
- LAUNCH→RUN: always, after one cycle.
- RUN→PUBLISH: done arrives and the operation asked for a digest.
- RUN→IDLE: done arrives and the operation did not ask for a digest.
- PUBLISH→IDLE: the full flag is 0, so the commit happens.

Top module: `hbuf_ctrl_top`

## Requirements
- R1: After reset every stored bit is 0. `bus_rdata` reads 0x0000_0004, which is only ready-for-data at bit 2, and no start or commit pulse is driven.
- R2: Bits 3, 4 and 8–31 of `bus_rdata` always read 0, and writing 1s to them starts nothing and changes nothing.
- R3: Writing 1 to bit 1 (data-available) sets it. In IDLE the next clock enters LAUNCH, where `core_start` is high for exactly one cycle. The flags are `core_data`=bit 1, `core_pad`=bit 5 and `core_dig`=bit 6, as those bits read just before launch. Bit 1 reads 0 from that cycle on.
- R4: Bit 2 (ready-for-data) reads 1 only in IDLE and reads 0 from LAUNCH until done returns the sequencer to IDLE. A data-available write made while bit 2 is 0 stays pending and launches the next block once IDLE is reached.
- R5: Bit 5 (pad) written alone in IDLE launches an operation with `core_data`=0 and `core_pad`=1. Bit 5 clears at launch.
- R6: Bit 6 (get-digest) written alone in IDLE launches a snapshot with `core_data`=0, `core_pad`=0 and `core_dig`=1. After done, a digest is committed.
- R7: An operation launched with `core_dig`=1 raises `dig_commit` in the PUBLISH cycle after done, provided bit 0 is 0. Bit 6 stays 1 until that commit and then clears. An operation without a digest returns to IDLE with no commit.
- R8: A commit sets bit 0 (output-full). Writing 1 to bit 0 clears it, and writing 0 has no effect.
- R9: While bit 0 is 1, PUBLISH holds and `dig_commit` stays low. In the cycle after the host's write-1 clears bit 0, `dig_commit` is 1.
- R10: Bit 7 (DMA pad) is write-1-to-set and appears as the level `dma_pad`. It launches nothing and clears on a `dma_last` pulse.
- R11: When a host write of 1 and an internal clear hit the same request bit at the same clock edge, the bit ends at 1. This covers bit 1 at launch and bit 7 at `dma_last`.
- R12: With several requests pending in IDLE, one launch carries all of them: data-available takes pad and get-digest along, and pad alone takes get-digest along.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe for the control word |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Control word as read by the host |
| core_start | output | 1 | One-cycle launch pulse to the hash core |
| core_data | output | 1 | Launch carries the loaded input block |
| core_pad | output | 1 | Launch asks for final padding |
| core_dig | output | 1 | Launch asks for a digest to be published |
| core_done | input | 1 | Core finished the launched operation (pulse) |
| dig_commit | output | 1 | Write the core's digest into the output registers now |
| dma_last | input | 1 | Last DMA block has arrived (pulse) |
| dma_pad | output | 1 | DMA-path padding request level |

## Verification
The bench builds the block with its default 32-bit register word, which is the only configuration, since the bit positions are fixed. The three launch-related request bits give just eight write patterns. The bench sweeps all eight and derives the expected start flags, commit and full-flag outcome from the pattern bits by arithmetic. Directed sequences then reach the orderings the sweep cannot: a second block queued while RUN is active, a pad-only request after an aligned block, a commit stalled behind an uncleared full flag, and the same-edge set-versus-clear collisions.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
    localparam int REG_W  = 32;
    localparam int B_FULL = 0;
    localparam int B_DAV  = 1;
    localparam int B_RDY  = 2;
    localparam int B_PAD  = 5;
    localparam int B_DIG  = 6;
    localparam int B_DPAD = 7;
    localparam int N_REQ  = 4;
    // request bit positions, indexed by request slot
    localparam int REQ_POS [N_REQ] = '{B_DAV, B_PAD, B_DIG, B_DPAD};
    localparam int SLOT_DAV  = 0;
    localparam int SLOT_PAD  = 1;
    localparam int SLOT_DIG  = 2;
    localparam int SLOT_DPAD = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LAUNCH  = 2'd1,
        ST_RUN     = 2'd2,
        ST_PUBLISH = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic data;
        logic pad;
        logic dig;
    } launch_t;
endpackage

// File: rtl/hbuf_req_bit.sv
module hbuf_req_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // set has priority so that no request is lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/hbuf_csr.sv
module hbuf_csr
    import hbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             clr_dav,
    input  logic             clr_pad,
    input  logic             clr_dig,
    input  logic             clr_dpad,
    input  logic             set_full,
    input  logic             ready,
    output logic [REG_W-1:0] bus_rdata,
    output logic             dav,
    output logic             pad,
    output logic             dig,
    output logic             dpad,
    output logic             full
);
    logic [N_REQ-1:0] req_set;
    logic [N_REQ-1:0] req_clr;
    logic [N_REQ-1:0] req_q;
    logic             full_clr;
    logic             wdata_unused;

    assign req_clr[SLOT_DAV]  = clr_dav;
    assign req_clr[SLOT_PAD]  = clr_pad;
    assign req_clr[SLOT_DIG]  = clr_dig;
    assign req_clr[SLOT_DPAD] = clr_dpad;

    for (genvar i = 0; i < N_REQ; i++) begin : g_req
        assign req_set[i] = bus_wr & bus_wdata[REQ_POS[i]];
        hbuf_req_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (req_set[i]),
            .clr_i (req_clr[i]),
            .q_o   (req_q[i])
        );
    end

    // output-full: commit sets (priority), host write-1 clears
    assign full_clr = bus_wr & bus_wdata[B_FULL];
    hbuf_req_bit u_full (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_full),
        .clr_i (full_clr),
        .q_o   (full)
    );

    assign dav  = req_q[SLOT_DAV];
    assign pad  = req_q[SLOT_PAD];
    assign dig  = req_q[SLOT_DIG];
    assign dpad = req_q[SLOT_DPAD];

    assign wdata_unused = ^{bus_wdata[REG_W-1:8], bus_wdata[4:2]};

    always_comb begin
        bus_rdata         = '0;
        bus_rdata[B_FULL] = full;
        bus_rdata[B_DAV]  = dav;
        bus_rdata[B_RDY]  = ready;
        bus_rdata[B_PAD]  = pad;
        bus_rdata[B_DIG]  = dig;
        bus_rdata[B_DPAD] = dpad;
    end

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[4:3] == 2'b00) && (bus_rdata[REG_W-1:8] == '0));

    // R3
    dav_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_dav && !(bus_wr && bus_wdata[B_DAV])) |=> !dav);

    // R8
    full_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[B_FULL] && !set_full) |=> !full);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[B_DPAD]) |=> dpad);
endmodule

// File: rtl/hbuf_seq.sv
module hbuf_seq
    import hbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dav,
    input  logic pad,
    input  logic dig,
    input  logic full,
    input  logic core_done,
    output logic core_start,
    output logic core_data,
    output logic core_pad,
    output logic core_dig,
    output logic dig_commit,
    output logic ready,
    output logic clr_dav,
    output logic clr_pad,
    output logic clr_dig
);
    seq_state_t state_q, state_d;
    launch_t    op_q;
    logic       any_req;

    assign any_req = dav | pad | dig;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && any_req) begin
                op_q.data <= dav;
                op_q.pad  <= pad;
                op_q.dig  <= dig;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (any_req)   state_d = ST_LAUNCH;
            ST_LAUNCH:                 state_d = ST_RUN;
            ST_RUN:     if (core_done) state_d = op_q.dig ? ST_PUBLISH : ST_IDLE;
            ST_PUBLISH: if (!full)     state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        core_start = 1'b0;
        dig_commit = 1'b0;
        ready      = 1'b0;
        clr_dav    = 1'b0;
        clr_pad    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready   = 1'b1;
                clr_dav = dav;
                clr_pad = pad;
            end
            ST_LAUNCH:  core_start = 1'b1;
            ST_RUN:     ;
            ST_PUBLISH: dig_commit = !full;
            default:    ;
        endcase
        core_data = op_q.data;
        core_pad  = op_q.pad;
        core_dig  = op_q.dig;
        clr_dig   = dig_commit;
    end

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R4
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !ready);

    // R7
    commit_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_commit |=> ready);

    // R9
    commit_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_commit |-> !full);
endmodule

// File: rtl/hbuf_ctrl_top.sv
module hbuf_ctrl_top
    import hbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             core_start,
    output logic             core_data,
    output logic             core_pad,
    output logic             core_dig,
    input  logic             core_done,
    output logic             dig_commit,
    input  logic             dma_last,
    output logic             dma_pad
);
    logic dav, pad, dig, full, ready;
    logic clr_dav, clr_pad, clr_dig;

    hbuf_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .clr_dav   (clr_dav),
        .clr_pad   (clr_pad),
        .clr_dig   (clr_dig),
        .clr_dpad  (dma_last),
        .set_full  (dig_commit),
        .ready     (ready),
        .bus_rdata (bus_rdata),
        .dav       (dav),
        .pad       (pad),
        .dig       (dig),
        .dpad      (dma_pad),
        .full      (full)
    );

    hbuf_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dav        (dav),
        .pad        (pad),
        .dig        (dig),
        .full       (full),
        .core_done  (core_done),
        .core_start (core_start),
        .core_data  (core_data),
        .core_pad   (core_pad),
        .core_dig   (core_dig),
        .dig_commit (dig_commit),
        .ready      (ready),
        .clr_dav    (clr_dav),
        .clr_pad    (clr_pad),
        .clr_dig    (clr_dig)
    );

    // R8
    commit_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_commit |=> bus_rdata[B_FULL]);

    // R1
    no_start_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !core_start && !dig_commit);
endmodule

// File: tb/hbuf_ctrl_tb_top.sv
module hbuf_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_start, core_data, core_pad, core_dig;
    logic        core_done = 1'b0;
    logic        dig_commit;
    logic        dma_last = 1'b0;
    logic        dma_pad;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hbuf_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .core_start(core_start), .core_data(core_data),
        .core_pad(core_pad), .core_dig(core_dig), .core_done(core_done),
        .dig_commit(dig_commit), .dma_last(dma_last), .dma_pad(dma_pad)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a negative edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] v);
        bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic done_pulse();
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 reset word", bus_rdata, 32'h4);
        chk("R1 no start", {31'd0, core_start}, 32'd0);

        // R2 reserved bits
        wr(32'hFFFF_FF18);
        chk("R2 reserved read", bus_rdata, 32'h4);
        step();
        chk("R2 no launch", {31'd0, core_start}, 32'd0);

        // sweep: all combinations of data / pad / digest written together
        for (int c = 0; c < 8; c++) begin
            logic d, p, g;
            logic [31:0] v;
            d = c[0]; p = c[1]; g = c[2];
            v = (32'(d) << 1) | (32'(p) << 5) | (32'(g) << 6);
            wr(v);
            chk("R3 pending bits", bus_rdata & 32'h62, v);
            if (c == 0) begin
                step(); step();
                chk("R3 idle no start", {31'd0, core_start}, 32'd0);
                continue;
            end
            step();
            chk("R3 start", {31'd0, core_start}, 32'd1);
            chk("R12 flags", {29'd0, core_data, core_pad, core_dig}, {29'd0, d, p, g});
            chk("R4 ready low", {31'd0, bus_rdata[2]}, 32'd0);
            chk("R3 R5 consumed", bus_rdata & 32'h62, 32'(g) << 6);
            step();
            chk("R3 one-cycle", {31'd0, core_start}, 32'd0);
            done_pulse();
            if (g) begin
                chk("R7 R6 commit", {31'd0, dig_commit}, 32'd1);
                step();
                chk("R8 full set, R7 dig cleared", bus_rdata, 32'h5);
                chk("R7 single commit", {31'd0, dig_commit}, 32'd0);
                wr(32'h1);
                chk("R8 w1c", bus_rdata, 32'h4);
            end else begin
                chk("R7 no commit", {31'd0, dig_commit}, 32'd0);
                chk("R4 back idle", bus_rdata, 32'h4);
            end
        end

        // R8 write 0 no effect, R9 stall while full
        wr(32'h40); step(); step(); done_pulse();
        chk("R6 snapshot commit", {31'd0, dig_commit}, 32'd1);
        step();
        wr(32'h0);
        chk("R8 write0 no effect", {31'd0, bus_rdata[0]}, 32'd1);
        wr(32'h40); step();
        chk("R6 snapshot launch", {29'd0, core_data, core_pad, core_dig}, 32'd1);
        step(); done_pulse();
        for (int k = 0; k < 3; k++) begin
            chk("R9 stalled", {31'd0, dig_commit}, 32'd0);
            chk("R9 busy while stalled", {31'd0, bus_rdata[2]}, 32'd0);
            chk("R7 dig pending", {31'd0, bus_rdata[6]}, 32'd1);
            step();
        end
        wr(32'h1);
        chk("R9 commit after release", {31'd0, dig_commit}, 32'd1);
        step();
        chk("R8 full again", bus_rdata, 32'h5);
        wr(32'h1);

        // R4 back-to-back gated by ready
        wr(32'h2); step();
        chk("R4 launch 1", {31'd0, core_start}, 32'd1);
        step();
        wr(32'h2);
        chk("R4 queued while busy", bus_rdata & 32'h6, 32'h2);
        chk("R4 no start while busy", {31'd0, core_start}, 32'd0);
        done_pulse();
        chk("R4 ready back", {31'd0, bus_rdata[2]}, 32'd1);
        step();
        chk("R4 launch 2", {30'd0, core_start, core_data}, 32'd3);
        step(); done_pulse();
        chk("R4 idle", bus_rdata, 32'h4);

        // R5 late pad after an aligned block
        wr(32'h2); step(); step(); done_pulse();
        wr(32'h20); step();
        chk("R5 pad-only launch", {28'd0, core_start, core_data, core_pad, core_dig}, 32'hA);
        step(); done_pulse();
        chk("R5 no commit", {31'd0, dig_commit}, 32'd0);
        chk("R5 idle", bus_rdata, 32'h4);

        // R11 set wins at launch
        bus_wr = 1'b1; bus_wdata = 32'h2;
        step(); step();
        bus_wr = 1'b0; bus_wdata = '0;
        chk("R11 launch", {31'd0, core_start}, 32'd1);
        chk("R11 dav kept", {31'd0, bus_rdata[1]}, 32'd1);
        step(); done_pulse(); step();
        chk("R11 second launch", {31'd0, core_start}, 32'd1);
        step(); done_pulse();
        chk("R11 idle", bus_rdata, 32'h4);

        // R10 DMA pad
        wr(32'h80);
        chk("R10 set", {30'd0, bus_rdata[7], dma_pad}, 32'd3);
        step();
        chk("R10 no launch", {31'd0, core_start}, 32'd0);
        wr(32'h0);
        chk("R10 write0", {31'd0, dma_pad}, 32'd1);
        dma_last = 1'b1; step(); dma_last = 1'b0;
        chk("R10 clear on last", {31'd0, dma_pad}, 32'd0);
        wr(32'h80);
        bus_wr = 1'b1; bus_wdata = 32'h80; dma_last = 1'b1;
        step();
        bus_wr = 1'b0; bus_wdata = '0; dma_last = 1'b0;
        chk("R11 dma set wins", {31'd0, dma_pad}, 32'd1);
        dma_last = 1'b1; step(); dma_last = 1'b0;
        chk("R10 final", bus_rdata, 32'h4);

        finished = 1;
        summary();
        $finish;
    end
endmodule